// File: doc/BRIEF.md
# Dual-Path Registered/Transparent Bus Driver

This block drives a 12-bit data word onto two identical output copies. A path-select input chooses the source. In the transparent path, the A inputs reach both copies in the same cycle without passing through any register. In the registered path, the A inputs are captured on the rising clock edge, and the copies then show the captured word.

A load-width input controls which bits are captured. With a full load, every bit is written. With an upper-only load, the top bits (bits 11..8 at the default parameters) are written and the lower bits (7..0) keep their old values. The capture register keeps loading in both paths.

A single drive-off input marks both copies as not driven. Tri-state is modelled as a valid flag beside each data vector, and the flag is the inverse of that input. Drive-off only touches the flags. The register goes on loading or holding exactly as it would otherwise. A synchronous active-high reset clears the register to zero.

The controls are decoded into three named states, each with two values:
- The path-select state `path_sel_t` is `PATH_REGISTER` when `bypass`=0 and `PATH_BYPASS` when `bypass`=1.
- The load state `load_kind_t` is `LOAD_ALL` when `partial_load`=0 and `LOAD_UPPER` when `partial_load`=1.
- The drive state `drive_t` is `DRIVE_ON` when `out_disable`=0 and `DRIVE_OFF` when `out_disable`=1.

The register moves between contents on these transitions:
- **reset-clear**: on a clock edge with `rst`=1, all bits become 0.
- **full-capture**: on a clock edge with `rst`=0 and `LOAD_ALL`, all bits take `a_in`.
- **upper-capture**: on a clock edge with `rst`=0 and `LOAD_UPPER`, bits [WIDTH-1:HOLD_BITS] take `a_in` and bits [HOLD_BITS-1:0] hold.

Top module: `dual_path_bus_driver`

## Requirements
- R1: With `bypass`=1, `y_main` and `y_copy` equal `a_in` in the same cycle, with no clock edge needed.
- R2: With `bypass`=0, after a clock edge where `rst`=0 and `partial_load`=0, both copies show the full `a_in` value that was present at that edge.
- R3: After a clock edge where `rst`=0 and `partial_load`=1, the copies show new bits 11..8 (bits [WIDTH-1:HOLD_BITS]) from `a_in`, and bits 7..0 unchanged, when viewed with `bypass`=0.
- R4: `y_main` equals `y_copy`, and `y_main_valid` equals `y_copy_valid`, in every cycle.
- R5: `y_main_valid` and `y_copy_valid` are 1 when `out_disable`=0 and 0 when `out_disable`=1, in the same cycle.
- R6: Capture continues while `out_disable`=1. Words loaded during drive-off appear on the copies once drive-off ends.
- R7: A clock edge with `rst`=1 clears the register. With `bypass`=0 the copies then read 0.
- R8: The register keeps loading under `bypass`=1, following `partial_load`. On returning to `bypass`=0, the copies show the word captured at the last edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset of the capture register |
| a_in | input | WIDTH | Data word |
| bypass | input | 1 | 1 = transparent path, 0 = registered path |
| partial_load | input | 1 | 1 = load upper bits only, 0 = load all bits |
| out_disable | input | 1 | 1 = both copies not driven |
| y_main | output | WIDTH | First output copy |
| y_main_valid | output | 1 | Drive flag of the first copy |
| y_copy | output | WIDTH | Second output copy |
| y_copy_valid | output | 1 | Drive flag of the second copy |

## Verification
The bench builds the block at its defaults: WIDTH=12 and HOLD_BITS=8. At this size, all 4096 input words can be swept through the transparent path. A second sweep runs 4096 cycles through the registered path. In that sweep the load width, the drive-off input and the path select change on different arithmetic cadences. This covers held lower bytes, loads made while drive-off is asserted, and loads made while bypassed, each in many combinations of data.

// File: rtl/driver_pkg.sv
package driver_pkg;

    // Source of the output copies
    typedef enum logic {
        PATH_REGISTER = 1'b0,
        PATH_BYPASS   = 1'b1
    } path_sel_t;

    // Which bit groups the capture register writes
    typedef enum logic {
        LOAD_ALL   = 1'b0,
        LOAD_UPPER = 1'b1
    } load_kind_t;

    // Drive state of the output copies
    typedef enum logic {
        DRIVE_ON  = 1'b0,
        DRIVE_OFF = 1'b1
    } drive_t;

endpackage

// File: rtl/capture_reg.sv
module capture_reg
    import driver_pkg::*;
#(
    parameter int WIDTH     = 12,
    parameter int HOLD_BITS = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  load_kind_t       kind,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    localparam int UPPER_BITS = WIDTH - HOLD_BITS;

    logic [WIDTH-1:0] q_r;
    logic [WIDTH-1:0] q_next;
    logic             lower_we;

    // Only the lower group depends on the load kind.
    always_comb begin
        unique case (kind)
            LOAD_ALL:   lower_we = 1'b1;
            LOAD_UPPER: lower_we = 1'b0;
            default:    lower_we = 1'b1;
        endcase
    end

    // Next value, built lane by lane.
    for (genvar i = 0; i < WIDTH; i++) begin : g_lane
        if (i < HOLD_BITS) begin : g_low
            assign q_next[i] = lower_we ? d[i] : q_r[i];
        end else begin : g_high
            assign q_next[i] = d[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q_r <= '0;
        end else begin
            q_r <= q_next;
        end
    end

    assign q = q_r;

    logic unused_ok;
    assign unused_ok = (UPPER_BITS > 0);
endmodule

// File: rtl/path_select.sv
module path_select
    import driver_pkg::*;
#(
    parameter int WIDTH = 12
) (
    input  path_sel_t        sel,
    input  logic [WIDTH-1:0] reg_q,
    input  logic [WIDTH-1:0] direct,
    output logic [WIDTH-1:0] word
);
    always_comb begin
        unique case (sel)
            PATH_REGISTER: word = reg_q;
            PATH_BYPASS:   word = direct;
            default:       word = reg_q;
        endcase
    end
endmodule

// File: rtl/output_copy.sv
module output_copy
    import driver_pkg::*;
#(
    parameter int WIDTH = 12
) (
    input  drive_t           drive,
    input  logic [WIDTH-1:0] word,
    output logic [WIDTH-1:0] data,
    output logic             valid
);
    always_comb begin
        data = word;
        unique case (drive)
            DRIVE_ON:  valid = 1'b1;
            DRIVE_OFF: valid = 1'b0;
            default:   valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/dual_path_bus_driver.sv
module dual_path_bus_driver
    import driver_pkg::*;
#(
    parameter int WIDTH     = 12,
    parameter int HOLD_BITS = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] a_in,
    input  logic             bypass,
    input  logic             partial_load,
    input  logic             out_disable,
    output logic [WIDTH-1:0] y_main,
    output logic             y_main_valid,
    output logic [WIDTH-1:0] y_copy,
    output logic             y_copy_valid
);
    localparam int NUM_COPIES = 2;

    path_sel_t  path_state;
    load_kind_t load_state;
    drive_t     drive_state;

    assign path_state  = bypass       ? PATH_BYPASS : PATH_REGISTER;
    assign load_state  = partial_load ? LOAD_UPPER  : LOAD_ALL;
    assign drive_state = out_disable  ? DRIVE_OFF   : DRIVE_ON;

    logic [WIDTH-1:0] reg_q;
    logic [WIDTH-1:0] sel_word;

    capture_reg #(.WIDTH(WIDTH), .HOLD_BITS(HOLD_BITS)) u_capture (
        .clk  (clk),
        .rst  (rst),
        .kind (load_state),
        .d    (a_in),
        .q    (reg_q)
    );

    path_select #(.WIDTH(WIDTH)) u_path (
        .sel    (path_state),
        .reg_q  (reg_q),
        .direct (a_in),
        .word   (sel_word)
    );

    logic [NUM_COPIES-1:0][WIDTH-1:0] copy_data;
    logic [NUM_COPIES-1:0]            copy_valid;

    for (genvar c = 0; c < NUM_COPIES; c++) begin : g_copy
        output_copy #(.WIDTH(WIDTH)) u_out (
            .drive (drive_state),
            .word  (sel_word),
            .data  (copy_data[c]),
            .valid (copy_valid[c])
        );
    end

    assign y_main       = copy_data[0];
    assign y_main_valid = copy_valid[0];
    assign y_copy       = copy_data[1];
    assign y_copy_valid = copy_valid[1];
endmodule

// File: rtl/driver_checker.sv
module driver_checker #(
    parameter int WIDTH     = 12,
    parameter int HOLD_BITS = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [WIDTH-1:0] a_in,
    input logic             bypass,
    input logic             partial_load,
    input logic             out_disable,
    input logic [WIDTH-1:0] y_main,
    input logic             y_main_valid,
    input logic [WIDTH-1:0] y_copy,
    input logic             y_copy_valid
);
    // R1
    bypass_follow_chk: assert property (@(posedge clk) disable iff (rst)
        bypass |-> (y_main == a_in));

    // R2
    full_load_chk: assert property (@(posedge clk) disable iff (rst)
        (!bypass && $past(!rst) && $past(!partial_load)) |-> (y_main == $past(a_in)));

    // R3
    upper_load_chk: assert property (@(posedge clk) disable iff (rst)
        (!bypass && $past(!bypass) && $past(!rst) && $past(partial_load)) |->
        ((y_main[HOLD_BITS-1:0] == $past(y_main[HOLD_BITS-1:0])) &&
         (y_main[WIDTH-1:HOLD_BITS] == $past(a_in[WIDTH-1:HOLD_BITS]))));

    // R4
    copies_match_chk: assert property (@(posedge clk) disable iff (rst)
        (y_main == y_copy) && (y_main_valid == y_copy_valid));

    // R5
    drive_flag_chk: assert property (@(posedge clk) disable iff (rst)
        y_main_valid != out_disable);

    // R7
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && !bypass) |-> (y_main == '0));
endmodule

bind dual_path_bus_driver driver_checker #(.WIDTH(WIDTH), .HOLD_BITS(HOLD_BITS)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .a_in         (a_in),
    .bypass       (bypass),
    .partial_load (partial_load),
    .out_disable  (out_disable),
    .y_main       (y_main),
    .y_main_valid (y_main_valid),
    .y_copy       (y_copy),
    .y_copy_valid (y_copy_valid)
);

// File: tb/dual_path_bus_driver_tb.sv
module dual_path_bus_driver_tb;
    localparam int W    = 12;
    localparam int HB   = 8;
    localparam int HALF = 2;   // 4 ns period

    logic          clk = 1'b0;
    logic          rst;
    logic [W-1:0]  a_in;
    logic          bypass, partial_load, out_disable;
    logic [W-1:0]  y_main, y_copy;
    logic          y_main_valid, y_copy_valid;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    logic [W-1:0] exp_q;
    bit prev_rst, prev_dis, prev_byp, prev_pl;

    always #HALF clk = ~clk;

    dual_path_bus_driver #(.WIDTH(W), .HOLD_BITS(HB)) u_dut (
        .clk(clk), .rst(rst), .a_in(a_in), .bypass(bypass),
        .partial_load(partial_load), .out_disable(out_disable),
        .y_main(y_main), .y_main_valid(y_main_valid),
        .y_copy(y_copy), .y_copy_valid(y_copy_valid)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] expv);
        checks++;
        if (act !== expv) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // One cycle: drive at falling edge, check before rising edge, update model.
    task automatic step(input logic [W-1:0] a, input bit byp, input bit pl, input bit dis, input bit r);
        string tag;
        @(negedge clk);
        a_in = a; bypass = byp; partial_load = pl; out_disable = dis; rst = r;
        #1;
        // R5
        check("R5", {{(W-1){1'b0}}, y_main_valid}, {{(W-1){1'b0}}, !dis});
        // R4
        check("R4", y_copy, y_main);
        check("R4", {{(W-1){1'b0}}, y_copy_valid}, {{(W-1){1'b0}}, y_main_valid});
        if (byp) begin
            check("R1", y_main, a);
        end else begin
            if (prev_rst)      tag = "R7";
            else if (prev_dis) tag = "R6";
            else if (prev_byp) tag = "R8";
            else if (prev_pl)  tag = "R3";
            else               tag = "R2";
            check(tag, y_main, exp_q);
        end
        @(posedge clk);
        if (r)       exp_q = '0;
        else if (pl) exp_q = {a[W-1:HB], exp_q[HB-1:0]};
        else         exp_q = a;
        prev_rst = r; prev_dis = dis; prev_byp = byp; prev_pl = pl;
    endtask

    initial begin
        #(HALF * 2 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; a_in = '1; bypass = 1'b0; partial_load = 1'b0; out_disable = 1'b0;
        @(posedge clk);
        exp_q = '0; prev_rst = 1; prev_dis = 0; prev_byp = 0; prev_pl = 0;
        // R7: reset state while reset held, then after it drops
        step(12'hFFF, 0, 0, 0, 1);
        step(12'hA5A, 0, 0, 0, 0);
        step(12'h3C3, 0, 1, 0, 0);
        // R7: reset in the middle of activity
        step(12'h777, 0, 0, 0, 1);
        step(12'h111, 0, 0, 0, 0);

        // R1: every word through the transparent path, loads continue (R8)
        for (int v = 0; v < (1 << W); v++) begin
            step(v[W-1:0], 1, (v % 3) == 1, (v % 5) == 2, 0);
        end

        // R2/R3/R6/R8: registered sweep with mixed controls
        for (int v = 0; v < (1 << W); v++) begin
            logic [W-1:0] d;
            d = W'((v * 37) ^ (v >> 3));
            step(d, (v % 11) == 3, (v[0] ^ v[5]) == 1'b1, (v % 7) == 0, 0);
        end

        // R6: several loads while driven off, then view
        step(12'h0F0, 0, 0, 1, 0);
        step(12'hABC, 0, 1, 1, 0);
        step(12'h000, 0, 1, 0, 0);
        step(12'h000, 0, 0, 0, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule